// File: doc/BRIEF.md
# Three-Lane Block-Parallel FIR Filter

This block computes a three-tap FIR filter whose taps all look into the past: each output equals a·x(n−1) + b·x(n−2) + c·x(n−3), and no term uses the current sample. The input arrives three samples at a time, so one clock spans three sample periods. Each clock the block takes x(3k), x(3k+1) and x(3k+2) on three lanes and produces y(3k), y(3k+1) and y(3k+2).

The block has no single delay line. Every tap of every lane is wired straight to the lane that carries the sample it needs. When that sample belongs to the previous block, the tap reads it from a one-block history register. Products keep their full width. The three-term sum is clamped to the output width. All three results are registered together and leave with one valid flag, one clock after the block is accepted. The coefficients are elaboration parameters.

Top module: `fir3p_filter`

## Requirements
- R1: While reset is high, and on the first clock after it, out_valid is 0 and all three output lanes are 0.
- R2: out_valid is high in the clock directly after a clock in which in_valid was high. In every other clock it is low.
- R3: Lane 0 gives y(3k) = A·x(3k−1) + B·x(3k−2) + C·x(3k−3). All three operands come from the previously accepted block, taken from its lanes 2, 1 and 0 in that order.
- R4: Lane 1 gives y(3k+1) = A·x(3k) + B·x(3k−1) + C·x(3k−2). The first operand is current lane 0. The other two are previous-block lanes 2 and 1.
- R5: Lane 2 gives y(3k+2) = A·x(3k+1) + B·x(3k) + C·x(3k−1). The first two operands are current lanes 1 and 0. The last is previous-block lane 2.
- R6: Reset clears the history, so the first block after reset is computed as if every earlier sample were 0.
- R7: Only accepted blocks (in_valid high) enter the history. Idle clocks between blocks do not change which samples the next block treats as its past.
- R8: A sum above the largest signed value of OUT_W bits is output as that largest value (32767 at defaults).
- R9: A sum below the smallest signed value of OUT_W bits is output as that smallest value (−32768 at defaults).
- R10: In a clock after one with in_valid low, the three output lanes keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one edge per three samples |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The three input lanes carry a block this clock |
| x0 | input | DATA_W | Sample x(3k), signed |
| x1 | input | DATA_W | Sample x(3k+1), signed |
| x2 | input | DATA_W | Sample x(3k+2), signed |
| out_valid | output | 1 | The output lanes carry a new result block |
| y0 | output | OUT_W | Result y(3k), signed, saturated |
| y1 | output | OUT_W | Result y(3k+1), signed, saturated |
| y2 | output | OUT_W | Result y(3k+2), signed, saturated |

## Verification
The first stimulus places a single nonzero sample on one lane at a time, followed by zero blocks. This shows which coefficient each lane applies to which lane of the current or previous block, so a miswired tap or a swapped coefficient is exposed. Long pseudo-random streams cover sums in the normal range across block boundaries, and idle gaps within them separate history that moves on every clock from history that moves only on accepted blocks. Blocks of extreme values drive the sum past both output limits. A reset in the middle of the stream shows whether the history is cleared.

// File: rtl/fir3p_pkg.sv
package fir3p_pkg;
  localparam int LANES = 3;
  localparam int TAPS  = 3;

  // Index of the operand sample relative to the start of the current block:
  // non-negative values address the current block, negative ones the previous block.
  function automatic int tap_source(input int lane, input int delay);
    return lane - delay;
  endfunction
endpackage

// File: rtl/fir3p_history.sv
module fir3p_history
  import fir3p_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic signed [DATA_W-1:0] cur  [LANES],
  output logic signed [DATA_W-1:0] prev [LANES]
);
  for (genvar g = 0; g < LANES; g++) begin : g_hist
    always_ff @(posedge clk) begin
      if (rst) begin
        prev[g] <= '0;
      end else if (load) begin
        prev[g] <= cur[g];
      end
    end
  end
endmodule

// File: rtl/fir3p_lane.sv
module fir3p_lane
  import fir3p_pkg::*;
#(
  parameter int                    LANE     = 0,
  parameter int                    DATA_W   = 8,
  parameter int                    COEF_W   = 8,
  parameter int                    OUT_W    = 16,
  parameter logic [TAPS*COEF_W-1:0] COEF_VEC = '0
) (
  input  logic signed [DATA_W-1:0] cur  [LANES],
  input  logic signed [DATA_W-1:0] prev [LANES],
  output logic signed [OUT_W-1:0]  result
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int SUM_W  = PROD_W + $clog2(TAPS) + 1;

  logic signed [DATA_W-1:0] opnd [TAPS];
  logic signed [PROD_W-1:0] prod [TAPS];
  logic signed [SUM_W-1:0]  sum;

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    localparam int SRC = tap_source(LANE, t + 1);
    localparam logic signed [COEF_W-1:0] K = COEF_VEC[t*COEF_W +: COEF_W];
    if (SRC >= 0) begin : g_now
      assign opnd[t] = cur[SRC];
    end else begin : g_old
      assign opnd[t] = prev[SRC + LANES];
    end
    assign prod[t] = PROD_W'(opnd[t]) * PROD_W'(K);
  end

  always_comb begin
    sum = '0;
    for (int t = 0; t < TAPS; t++) begin
      sum = sum + {{(SUM_W-PROD_W){prod[t][PROD_W-1]}}, prod[t]};
    end
  end

  if (OUT_W >= SUM_W) begin : g_wide
    assign result = {{(OUT_W-SUM_W){sum[SUM_W-1]}}, sum};
  end else begin : g_clip
    logic fits;
    assign fits = (sum[SUM_W-1:OUT_W-1] == '0) || (sum[SUM_W-1:OUT_W-1] == '1);
    always_comb begin
      if (fits)
        result = sum[OUT_W-1:0];
      else if (sum[SUM_W-1])
        result = {1'b1, {(OUT_W-1){1'b0}}};
      else
        result = {1'b0, {(OUT_W-1){1'b1}}};
    end
  end
endmodule

// File: rtl/fir3p_filter.sv
module fir3p_filter
  import fir3p_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int OUT_W  = 16,
  parameter int COEF_A = 100,
  parameter int COEF_B = -90,
  parameter int COEF_C = 120
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] x0,
  input  logic signed [DATA_W-1:0] x1,
  input  logic signed [DATA_W-1:0] x2,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  y0,
  output logic signed [OUT_W-1:0]  y1,
  output logic signed [OUT_W-1:0]  y2
);
  localparam logic [COEF_W-1:0] KA = COEF_W'(COEF_A);
  localparam logic [COEF_W-1:0] KB = COEF_W'(COEF_B);
  localparam logic [COEF_W-1:0] KC = COEF_W'(COEF_C);
  // tap t (delay t+1) lives at bits [t*COEF_W +: COEF_W]
  localparam logic [TAPS*COEF_W-1:0] KVEC = {KC, KB, KA};

  logic signed [DATA_W-1:0] cur  [LANES];
  logic signed [DATA_W-1:0] prev [LANES];
  logic signed [OUT_W-1:0]  lane_out [LANES];
  logic signed [OUT_W-1:0]  y_q [LANES];
  logic                     v_q;

  assign cur[0] = x0;
  assign cur[1] = x1;
  assign cur[2] = x2;

  fir3p_history #(.DATA_W(DATA_W)) u_hist (
    .clk  (clk),
    .rst  (rst),
    .load (in_valid),
    .cur  (cur),
    .prev (prev)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    fir3p_lane #(
      .LANE(l), .DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .COEF_VEC(KVEC)
    ) u_lane (
      .cur    (cur),
      .prev   (prev),
      .result (lane_out[l])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        y_q[l] <= '0;
      end else if (in_valid) begin
        y_q[l] <= lane_out[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= in_valid;
  end

  assign out_valid = v_q;
  assign y0 = y_q[0];
  assign y1 = y_q[1];
  assign y2 = y_q[2];
endmodule

// File: rtl/fir3p_checker.sv
module fir3p_checker #(
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] y0,
  input logic signed [OUT_W-1:0] y1,
  input logic signed [OUT_W-1:0] y2
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && y0 == '0 && y1 == '0 && y2 == '0));

  // R2
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_valid) |=> out_valid);

  // R2
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    (!rst && !in_valid) |=> !out_valid);

  // R10
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!rst && !in_valid) |=> ($stable(y0) && $stable(y1) && $stable(y2)));
endmodule

bind fir3p_filter fir3p_checker #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .y0        (y0),
  .y1        (y1),
  .y2        (y2)
);

// File: tb/fir3p_filter_test.sv
module fir3p_filter_test;
  localparam int DW = 8;
  localparam int OW = 16;
  localparam int KA = 100;
  localparam int KB = -90;
  localparam int KC = 120;
  localparam int OMAX = 32767;
  localparam int OMIN = -32768;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] x0 = '0, x1 = '0, x2 = '0;
  logic out_valid;
  logic signed [OW-1:0] y0, y1, y2;

  int total = 0;
  int bad = 0;
  int smp [0:4095];
  int n = 0;
  int base = 0;
  int last [3];
  logic [31:0] seed = 32'h1234_5678;
  bit after_idle = 0;

  always #5 clk = ~clk;

  fir3p_filter #(.DATA_W(DW), .COEF_W(8), .OUT_W(OW),
                 .COEF_A(KA), .COEF_B(KB), .COEF_C(KC)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x0(x0), .x1(x1), .x2(x2),
    .out_valid(out_valid), .y0(y0), .y1(y1), .y2(y2));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int xs(input int k);
    return (k < base) ? 0 : smp[k];
  endfunction

  function automatic int rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[23:16]));
  endfunction

  // called at a negative edge; returns at the next negative edge after checking
  task automatic send_block(input int a0, input int a1, input int a2);
    int m;
    int expv [3];
    int got [3];
    string tag;
    m = n;
    smp[n] = a0; smp[n+1] = a1; smp[n+2] = a2;
    n += 3;
    for (int i = 0; i < 3; i++) begin
      expv[i] = KA*xs(m+i-1) + KB*xs(m+i-2) + KC*xs(m+i-3);
    end
    x0 = DW'(a0); x1 = DW'(a1); x2 = DW'(a2);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R2 out_valid after accepted block", int'(out_valid), 1);
    got[0] = int'(y0); got[1] = int'(y1); got[2] = int'(y2);
    for (int i = 0; i < 3; i++) begin
      if (expv[i] > OMAX) begin
        tag = "R8 high clamp"; expv[i] = OMAX;
      end else if (expv[i] < OMIN) begin
        tag = "R9 low clamp"; expv[i] = OMIN;
      end else if (m == base) begin
        tag = "R6 first block after reset";
      end else if (after_idle) begin
        tag = "R7 history across idle";
      end else if (i == 0) begin
        tag = "R3 lane0";
      end else if (i == 1) begin
        tag = "R4 lane1";
      end else begin
        tag = "R5 lane2";
      end
      check(tag, got[i], expv[i]);
      last[i] = expv[i];
    end
    after_idle = 0;
  endtask

  task automatic idle(input int cycles);
    in_valid = 1'b0;
    x0 = DW'(rnd8()); x1 = DW'(rnd8()); x2 = DW'(rnd8());
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk);
      @(negedge clk);
      check("R2 no valid when idle", int'(out_valid), 0);
      check("R10 y0 held", int'(y0), last[0]);
      check("R10 y1 held", int'(y1), last[1]);
      check("R10 y2 held", int'(y2), last[2]);
    end
    after_idle = 1;
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 y0 in reset", int'(y0), 0);
    check("R1 y1 in reset", int'(y1), 0);
    check("R1 y2 in reset", int'(y2), 0);
    rst = 1'b0;
    base = n;
    for (int i = 0; i < 3; i++) last[i] = 0;
    @(posedge clk);
    @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R6: first block after reset sees zero history
    send_block(5, -7, 11);
    // impulses on each lane, value set distinguishes coefficient placement
    for (int lane = 0; lane < 3; lane++) begin
      send_block(lane == 0 ? 1 : 0, lane == 1 ? 1 : 0, lane == 2 ? 1 : 0);
      send_block(0, 0, 0);
      send_block(lane == 0 ? -3 : 0, lane == 1 ? -3 : 0, lane == 2 ? -3 : 0);
      send_block(0, 0, 0);
    end
    // R3 R4 R5 pseudo-random stream with occasional gaps (R7, R10)
    for (int b = 0; b < 300; b++) begin
      send_block(rnd8() / 4, rnd8() / 4, rnd8() / 4);
      if (b % 37 == 5) idle(1 + b % 3);
    end
    // R8: push sum above the top limit
    send_block(127, -128, 127);
    send_block(127, -128, 127);
    send_block(-128, 127, -128);
    // R9: push sum below the bottom limit
    send_block(-128, 127, -128);
    send_block(-128, -128, -128);
    send_block(127, 127, 127);
    // full-range random stream, clamps and normal values mixed
    for (int b = 0; b < 200; b++) send_block(rnd8(), rnd8(), rnd8());
    idle(2);
    // R6: reset mid-stream clears history
    do_reset();
    send_block(-1, 2, -3);
    send_block(4, -5, 6);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule